// File: doc/BRIEF.md
# General-Purpose I/O Port with Combined Interrupt

This block is a 32-pin general-purpose I/O port behind a small register bus: one write strobe with an address and write data, and a read-data bus that follows the address in the same cycle. Each pin has its own bit in every register. A pin can drive a data value, hold a value that toggles at a fixed rate, or act as an input. Inputs are synchronised and may be inverted per pin before software or the interrupt logic sees them.

Rising edges of each adjusted input are latched in a sticky cause register. Software clears cause bits by writing zeros. A single interrupt line merges two terms: masked edge causes and masked live input levels. Both masks come out of reset cleared, so no interrupt can be raised until software enables one.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, data-out, blink, polarity, cause, edge-mask and level-mask read 0. Output-enable reads all ones, `pad_en` is 0 and `irq` is 0.
- R2: `pad_en[i]` is 1 exactly when output-enable bit i is 0, and the output-enable bit is active-low. With blink bit i at 0, `pad_out[i]` equals data-out bit i.
- R3: The data-in register reads the two-flop-synchronised `pin_in` XORed with the polarity register, with bit i belonging to pin i. A pin change is visible there after two rising clock edges. A polarity change is visible at once.
- R4: A 0-to-1 transition of a bit of the adjusted input sets that cause bit on the next edge. With polarity bit 1, a falling raw pin therefore sets the cause bit and a rising raw pin does not.
- R5: A write to the cause register clears each bit written 0 and leaves each bit written 1 unchanged, so that a single pin can be acknowledged.
- R6: When a new edge on a pin coincides with a write that clears its cause bit, the bit ends up set.
- R7: `irq` is the OR, over all pins, of (cause AND edge-mask) and of (adjusted input AND level-mask).
- R8: While blink bit i is 1, `pad_out[i]` toggles once every `BLINK_HALF` clock cycles from a free-running prescaler that all pins share.
- R9: The register byte offsets are data-out 0x00, output-enable 0x04, blink 0x08, polarity 0x0C, data-in 0x10, cause 0x14, edge-mask 0x18 and level-mask 0x1C. Data-in is read-only, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pin_in | input | 32 | Raw pin levels (asynchronous) |
| pad_out | output | 32 | Output value for each pin |
| pad_en | output | 32 | Drive enable for each pin, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
A cause bit that is stuck or lost appears on the cause read-back and on `irq`. It shows up on the first edge after the synchronised input rises, which is three clock edges after the pin moves. A wrong synchroniser or polarity state shows up on the data-in read and on the level term of `irq` within two edges. A prescaler fault changes the spacing between `pad_out` toggles within one blink half-period. A clear-versus-set ordering fault shows up only when a clearing write lands on the same edge as a new pin edge, so the bench times one write to that exact cycle.

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int NPINS      = 32,
  parameter int ADDR_W     = 5,
  parameter int BLINK_HALF = 8,
  parameter logic [ADDR_W-1:0] OFS_DOUT  = 5'h00,
  parameter logic [ADDR_W-1:0] OFS_OEN   = 5'h04,
  parameter logic [ADDR_W-1:0] OFS_BLINK = 5'h08,
  parameter logic [ADDR_W-1:0] OFS_POL   = 5'h0C,
  parameter logic [ADDR_W-1:0] OFS_DIN   = 5'h10,
  parameter logic [ADDR_W-1:0] OFS_CAUSE = 5'h14,
  parameter logic [ADDR_W-1:0] OFS_EMASK = 5'h18,
  parameter logic [ADDR_W-1:0] OFS_LMASK = 5'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_en,
  output logic              irq
);
  localparam int PW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [PW-1:0] PS_LAST = PW'(BLINK_HALF - 1);

  logic [NPINS-1:0] dout_q, oen_q, blink_q, pol_q, cause_q, emask_q, lmask_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, adj, rise;
  logic [PW-1:0]    ps_q;
  logic             phase_q;

  assign adj  = sync2_q ^ pol_q;
  assign rise = adj & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= adj;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oen_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr_en) begin
      if (addr == OFS_DOUT)  dout_q  <= wdata;
      if (addr == OFS_OEN)   oen_q   <= wdata;
      if (addr == OFS_BLINK) blink_q <= wdata;
      if (addr == OFS_POL)   pol_q   <= wdata;
      if (addr == OFS_EMASK) emask_q <= wdata;
      if (addr == OFS_LMASK) lmask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else if (wr_en && addr == OFS_CAUSE) cause_q <= (cause_q & wdata) | rise;
    else cause_q <= cause_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q    <= '0;
      phase_q <= 1'b0;
    end else if (ps_q == PS_LAST) begin
      ps_q    <= '0;
      phase_q <= ~phase_q;
    end else begin
      ps_q <= ps_q + 1'b1;
    end
  end

  assign pad_out = (blink_q & {NPINS{phase_q}}) | (~blink_q & dout_q);
  assign pad_en  = ~oen_q;
  assign irq     = |((cause_q & emask_q) | (adj & lmask_q));

  always_comb begin
    rdata = '0;
    if (addr == OFS_DOUT)  rdata = dout_q;
    if (addr == OFS_OEN)   rdata = oen_q;
    if (addr == OFS_BLINK) rdata = blink_q;
    if (addr == OFS_POL)   rdata = pol_q;
    if (addr == OFS_DIN)   rdata = adj;
    if (addr == OFS_CAUSE) rdata = cause_q;
    if (addr == OFS_EMASK) rdata = emask_q;
    if (addr == OFS_LMASK) rdata = lmask_q;
  end

  AST_CAUSE_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(cause_q) & ~cause_q)) |-> $past(wr_en && addr == OFS_CAUSE)); // R5
  AST_EDGE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> (($past(rise) & ~cause_q) == '0)); // R6
  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (emask_q == '0 && lmask_q == '0) |-> !irq); // R7
  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_q != PS_LAST) |=> $stable(phase_q)); // R8
endmodule

// File: tb/sim_gpio_port_irq.sv
module sim_gpio_port_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_out, pad_en, pin_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  localparam logic [4:0] A_DOUT = 5'h00, A_OEN = 5'h04, A_BLINK = 5'h08, A_POL = 5'h0C,
                         A_DIN = 5'h10, A_CAUSE = 5'h14, A_EMASK = 5'h18, A_LMASK = 5'h1C;

  gpio_port_irq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                    .rdata(rdata), .pin_in(pin_in), .pad_out(pad_out), .pad_en(pad_en), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 rdata, 1 irq, 2 pad_out, 3 pad_en
  task automatic expect_at(input int kind, input logic [4:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = {31'b0, irq};
          2: act = pad_out;
          default: act = pad_en;
        endcase
        chk(act, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    expect_at(0, A_DOUT, 32'h0, "R1 dout");
    expect_at(0, A_OEN, 32'hffffffff, "R1 oen");
    expect_at(0, A_EMASK, 32'h0, "R1 emask");
    expect_at(0, A_LMASK, 32'h0, "R1 lmask");
    expect_at(0, A_CAUSE, 32'h0, "R1 cause");
    expect_at(1, A_DOUT, 32'h0, "R1 irq");
    expect_at(3, A_DOUT, 32'h0, "R1 pad_en");
    // R2 drive enable and output data
    wr(A_OEN, 32'hffff0000);
    wr(A_DOUT, 32'h0000a5a5);
    expect_at(3, A_DOUT, 32'h0000ffff, "R2 pad_en");
    expect_at(2, A_DOUT, 32'h0000a5a5, "R2 pad_out");
    // R3 input with polarity
    @(negedge clk) pin_in = 32'h12340000;
    settle();
    expect_at(0, A_DIN, 32'h12340000, "R3 din raw");
    wr(A_POL, 32'h000000ff);
    expect_at(0, A_DIN, 32'h123400ff, "R3 din inverted");
    expect_at(0, A_CAUSE, 32'h123400ff, "R4 rising adjusted sets cause");
    wr(A_CAUSE, 32'h0);
    expect_at(0, A_CAUSE, 32'h0, "R5 clear all");
    // R4 inverted pin: raw rise no cause, raw fall sets cause
    @(negedge clk) pin_in[0] = 1'b1;
    settle();
    expect_at(0, A_CAUSE, 32'h0, "R4 raw rise with inversion");
    @(negedge clk) pin_in[0] = 1'b0;
    settle();
    expect_at(0, A_CAUSE, 32'h1, "R4 raw fall with inversion");
    // R5 single-pin acknowledge
    @(negedge clk) pin_in[9] = 1'b1;
    settle();
    expect_at(0, A_CAUSE, 32'h201, "R4 second cause");
    wr(A_CAUSE, 32'hfffffffe);
    expect_at(0, A_CAUSE, 32'h200, "R5 ack bit0 only");
    // R6 coincident edge and clear
    @(negedge clk) pin_in[10] = 1'b1;
    @(negedge clk);
    wr(A_CAUSE, 32'h0);
    expect_at(0, A_CAUSE, 32'h400, "R6 set wins over clear");
    wr(A_CAUSE, 32'h0);
    // R7 interrupt combination
    wr(A_EMASK, 32'h00000800);
    expect_at(1, A_DOUT, 32'h0, "R7 masked edge idle");
    @(negedge clk) pin_in[11] = 1'b1;
    settle();
    expect_at(1, A_DOUT, 32'h1, "R7 edge irq");
    wr(A_EMASK, 32'h0);
    expect_at(1, A_DOUT, 32'h0, "R7 edge masked off");
    wr(A_CAUSE, 32'h0);
    wr(A_LMASK, 32'h00040000);
    expect_at(1, A_DOUT, 32'h1, "R7 level irq");
    wr(A_POL, 32'h000400ff);
    expect_at(1, A_DOUT, 32'h0, "R7 level inverted away");
    wr(A_LMASK, 32'h0);
    // R9 offsets and read-only data-in
    wr(A_BLINK, 32'h00000000);
    expect_at(0, A_POL, 32'h000400ff, "R9 pol readback");
    expect_at(0, A_DIN, 32'h12300eff, "R9 din before write");
    wr(A_DIN, 32'hffffffff);
    expect_at(0, A_DIN, 32'h12300eff, "R9 din write ignored");
    expect_at(0, A_DOUT, 32'h0000a5a5, "R9 dout unchanged");
    // R8 blink
    wr(A_BLINK, 32'h00000001);
    begin
      int toggles = 0;
      logic prevb;
      @(negedge clk); #2;
      prevb = pad_out[0];
      for (int k = 0; k < 16; k++) begin
        @(negedge clk); #2;
        if (pad_out[0] !== prevb) toggles++;
        prevb = pad_out[0];
        chk(pad_out[15:1] , 15'h52d2, "R8 non-blink pins hold");
      end
      chk(toggles, 2, "R8 toggles per 16 cycles");
    end
    wr(A_BLINK, 32'h0);
    expect_at(2, A_DOUT, 32'h0000a5a5, "R8 blink off restores data");
    expect_at(0, A_BLINK, 32'h0, "R9 blink readback");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule